// File: doc/BRIEF.md
# Pipelined Separate-Port Synchronous SRAM with Pass-Through

This block is a single-clock static memory with a write-data port and a read-data port that are physically separate. On every rising clock edge it captures the address, the write word, the write strobe, two chip selects and a pass-through control. One edge later the captured operation completes and its result is presented at the read-data port. The result is either the word held in the array or, when pass-through is requested, the captured write word itself. A write and a read can share one cycle and one address. In that case the old contents come out and the new word is stored.

An output enable is the only unclocked control. It gates an output-drive flag that stands in for tristate pads. When the flag is low the read-data port is forced to zero. Reads and writes can be mixed in any order on consecutive cycles with no idle cycle between them. A read that follows a write to the same address returns the new word. A synchronous reset empties the output pipeline and leaves the array untouched.

Top module: `sio_pipe_sram`

## Requirements
- R1: While reset is held and after its release, before any selected operation completes, `drive_o` is 0 and `dout_o` is 0.
- R2: An operation is selected only when `cs_n_i` = 0 and `cs_i` = 1. Any other combination writes nothing and gives `drive_o` = 0 after the next edge.
- R3: A selected operation with `wr_n_i` = 0 stores `din_i` at `addr_i`. A later selected read of that address with `thru_n_i` = 1 returns it.
- R4: A selected operation with `thru_n_i` = 1 and `wr_n_i` = 0 outputs the word the address held before the write.
- R5: A selected operation with `thru_n_i` = 0 outputs the captured `din_i`. When `wr_n_i` = 1 as well, the array is left unchanged.
- R6: The inputs captured at edge n reach `dout_o`/`drive_o` after edge n+1 and not after edge n alone.
- R7: `oe_n_i` = 1 forces `drive_o` = 0 and `dout_o` = 0 at once, with no clock edge. `drive_o` is 1 only when the completed operation was selected and `oe_n_i` = 0.
- R8: A selected read issued in the cycle right after a write to the same address returns the newly written word.
- R9: Reset does not alter the array contents. Words written before a reset pulse read back unchanged after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the pipeline state |
| addr_i | input | AW | Word address, captured each edge |
| din_i | input | DW | Write / pass-through word, captured each edge |
| wr_n_i | input | 1 | Write strobe, active low |
| cs_n_i | input | 1 | Chip select, active low |
| cs_i | input | 1 | Chip select, active high |
| thru_n_i | input | 1 | Pass-through request, active low |
| oe_n_i | input | 1 | Unclocked output enable, active low |
| dout_o | output | DW | Read-data word, zero when not driven |
| drive_o | output | 1 | Output-drive flag standing in for the pads |

## Verification
The hardest situation to reach is a same-address collision. Here a write and a read of one word share a cycle, or follow each other on consecutive cycles, so that the result depends on read-before-write ordering in the array. The random stimulus confines addresses to a sixteen-word window and makes about three quarters of the operations selected, so such collisions occur many times. Directed sequences force the exact write-then-read pair, a pass-through that must leave the array untouched, and a reset pulse between writes and reads. A second pair of directed steps toggles the output enable between clock edges to expose its unclocked path.

// File: rtl/sio_sram_pkg.sv
package sio_sram_pkg;

  typedef struct packed {
    logic sel;
    logic wr;
    logic thru;
  } sio_ctl_t;

  function automatic sio_ctl_t sio_decode(input logic cs_n, input logic cs,
                                          input logic wr_n, input logic thru_n);
    sio_ctl_t c;
    c.sel  = ~cs_n & cs;
    c.wr   = ~wr_n;
    c.thru = ~thru_n;
    return c;
  endfunction

endpackage

// File: rtl/sio_capture.sv
module sio_capture
  import sio_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  input  logic          wr_n_i,
  input  logic          cs_n_i,
  input  logic          cs_i,
  input  logic          thru_n_i,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] din_q,
  output sio_ctl_t      ctl_q
);

  sio_ctl_t ctl_d;

  always_comb ctl_d = sio_decode(cs_n_i, cs_i, wr_n_i, thru_n_i);

  always_ff @(posedge clk) begin
    addr_q <= addr_i;
    din_q  <= din_i;
    if (rst) ctl_q <= '0;
    else     ctl_q <= ctl_d;
  end

endmodule

// File: rtl/sio_array.sv
module sio_array #(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-first single port: the read register samples the old word
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end

  // R3: a write is present in the array after its edge
  assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    we |=> mem[$past(addr)] == $past(wdata));

  // R4: the read register carries the pre-write contents
  assert_read_old_R4: assert property (@(posedge clk) disable iff (rst)
    re |=> rdata == $past(mem[addr]));

endmodule

// File: rtl/sio_out_stage.sv
module sio_out_stage #(
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sel_i,
  input  logic          thru_i,
  input  logic [DW-1:0] din_i,
  input  logic [DW-1:0] rd_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] dout_o,
  output logic          drive_o
);

  logic          sel_q;
  logic          thru_q;
  logic [DW-1:0] pt_q;
  logic [DW-1:0] word;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b0;
      thru_q <= 1'b0;
      pt_q   <= '0;
    end else begin
      sel_q  <= sel_i;
      thru_q <= thru_i;
      pt_q   <= din_i;
    end
  end

  always_comb begin
    word    = thru_q ? pt_q : rd_i;
    drive_o = sel_q & ~oe_n_i;
    dout_o  = drive_o ? word : '0;
  end

  // R5: a selected pass-through presents the word captured one edge earlier
  assert_thru_copies_R5: assert property (@(posedge clk) disable iff (rst)
    (sel_i && thru_i) |=> word == $past(din_i));

endmodule

// File: rtl/sio_pipe_sram.sv
module sio_pipe_sram
  import sio_sram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  input  logic          wr_n_i,
  input  logic          cs_n_i,
  input  logic          cs_i,
  input  logic          thru_n_i,
  input  logic          oe_n_i,
  output logic [DW-1:0] dout_o,
  output logic          drive_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  sio_ctl_t      ctl_q;
  logic [DW-1:0] rd_word;
  logic          arr_we;
  logic          arr_re;

  sio_capture #(.AW(AW), .DW(DW)) u_cap (
    .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i), .wr_n_i(wr_n_i),
    .cs_n_i(cs_n_i), .cs_i(cs_i), .thru_n_i(thru_n_i),
    .addr_q(addr_q), .din_q(din_q), .ctl_q(ctl_q)
  );

  always_comb begin
    arr_we = ctl_q.sel & ctl_q.wr;
    arr_re = ctl_q.sel & ~ctl_q.thru;
  end

  sio_array #(.AW(AW), .DW(DW)) u_arr (
    .clk(clk), .rst(rst), .we(arr_we), .re(arr_re),
    .addr(addr_q), .wdata(din_q), .rdata(rd_word)
  );

  sio_out_stage #(.DW(DW)) u_out (
    .clk(clk), .rst(rst), .sel_i(ctl_q.sel), .thru_i(ctl_q.thru),
    .din_i(din_q), .rd_i(rd_word), .oe_n_i(oe_n_i),
    .dout_o(dout_o), .drive_o(drive_o)
  );

  // R2: a deselected capture leaves the port undriven after the next edge
  assert_desel_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !ctl_q.sel |=> !drive_o);

  // R6: a driven port always traces back to a selected capture one edge earlier
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    drive_o |-> $past(ctl_q.sel));

  // R7: an undriven port carries zero
  assert_undriven_zero_R7: assert property (@(posedge clk) disable iff (rst)
    !drive_o |-> dout_o == '0);

endmodule

// File: tb/sio_pipe_sram_tb.sv
module sio_pipe_sram_tb;

  localparam int AW = 10;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] din_i = '0;
  logic          wr_n_i = 1'b1;
  logic          cs_n_i = 1'b1;
  logic          cs_i = 1'b0;
  logic          thru_n_i = 1'b1;
  logic          oe_n_i = 1'b0;
  logic [DW-1:0] dout_o;
  logic          drive_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [DW-1:0] mdl [1<<AW];

  // expected results: e0 issued one cycle ago, e1 two cycles ago
  logic          e0_sel, e1_sel;
  logic [DW-1:0] e0_word, e1_word;
  string         e0_tag, e1_tag;
  logic          last_wr;
  logic [AW-1:0] last_addr;

  sio_pipe_sram #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .addr_i(addr_i), .din_i(din_i), .wr_n_i(wr_n_i),
    .cs_n_i(cs_n_i), .cs_i(cs_i), .thru_n_i(thru_n_i), .oe_n_i(oe_n_i),
    .dout_o(dout_o), .drive_o(drive_o)
  );

  always #5 clk = ~clk;

  function automatic logic [DW:0] expect_port(logic sel, logic [DW-1:0] w, logic oe_n);
    logic d;
    d = sel & ~oe_n;
    return {d, d ? w : {DW{1'b0}}};
  endfunction

  task automatic chk(string tag, logic [DW:0] act, logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: drive/dout actual=%0d/%h expected=%0d/%h",
               tag, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
    end
  endtask

  task automatic clear_pipe();
    e0_sel = 0; e1_sel = 0; e0_word = '0; e1_word = '0;
    e0_tag = "R2"; e1_tag = "R2"; last_wr = 0; last_addr = '0;
  endtask

  task automatic issue(logic [AW-1:0] a, logic [DW-1:0] d, logic w_n, logic s_n,
                       logic s, logic t_n, logic o_n, string tag);
    logic          sel;
    logic [DW-1:0] w;
    string         t;
    @(negedge clk);
    chk(e1_tag, {drive_o, dout_o}, expect_port(e1_sel, e1_word, oe_n_i));
    e1_sel = e0_sel; e1_word = e0_word; e1_tag = e0_tag;
    sel = !s_n && s;
    w = '0;
    if (!sel)        t = "R2";
    else if (!t_n)   t = "R5";
    else if (!w_n)   t = "R4";
    else if (last_wr && last_addr == a) t = "R8";
    else             t = "R3";
    if (sel) w = !t_n ? d : mdl[a];
    if (sel && !w_n) mdl[a] = d;
    if (o_n) t = "R7";
    if (tag != "") t = tag;
    e0_sel = sel; e0_word = w; e0_tag = t;
    last_wr = sel && !w_n; last_addr = a;
    addr_i = a; din_i = d; wr_n_i = w_n; cs_n_i = s_n; cs_i = s;
    thru_n_i = t_n; oe_n_i = o_n;
  endtask

  task automatic idle();
    issue('0, '0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd24681));
    clear_pipe();
    repeat (3) @(negedge clk);
    chk("R1", {drive_o, dout_o}, {1'b1'(0), {DW{1'b0}}});
    rst = 0;
    @(negedge clk);
    chk("R1", {drive_o, dout_o}, {1'b0, {DW{1'b0}}});

    // latency and asynchronous output enable, directed
    din_i = 18'h2A5C3; cs_n_i = 0; cs_i = 1; thru_n_i = 0; wr_n_i = 1; oe_n_i = 0;
    @(negedge clk);
    chk("R6", {drive_o, dout_o}, {1'b0, {DW{1'b0}}});
    @(negedge clk);
    chk("R6", {drive_o, dout_o}, {1'b1, 18'h2A5C3});
    oe_n_i = 1; #1;
    chk("R7", {drive_o, dout_o}, {1'b0, {DW{1'b0}}});
    oe_n_i = 0; #1;
    chk("R7", {drive_o, dout_o}, {1'b1, 18'h2A5C3});
    cs_n_i = 1; cs_i = 0; thru_n_i = 1;
    repeat (3) @(negedge clk);

    // preload the sixteen-word window
    for (int i = 0; i < 16; i++)
      issue(AW'(i), DW'(i * 4099 + 17), 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    // each deselect combination must not write
    issue(10'd3, 18'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, "R2");
    issue(10'd3, 18'h3FFFE, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R2");
    issue(10'd3, 18'h3FFFD, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R2");
    issue(10'd3, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    // pass-through without write leaves the word alone
    issue(10'd7, 18'h15555, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    issue(10'd7, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R5");
    // pass-through with write shows the new word and stores it
    issue(10'd8, 18'h0ABCD, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, "R5");
    issue(10'd8, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R3");
    // combined read/write returns old, following read returns new
    issue(10'd5, 18'h1F0F0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    issue(10'd5, '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
    issue(10'd9, 18'h00F0F, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R4");
    issue(10'd9, 18'h12345, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, "R8");

    for (int n = 0; n < 600; n++) begin
      logic s_n, s;
      int   c;
      c = $urandom % 4;
      if ($urandom % 4 != 0) begin s_n = 0; s = 1; end
      else begin s_n = (c != 1); s = (c == 2); end
      issue(AW'($urandom % 16), DW'($urandom), 1'($urandom), s_n, s,
            1'($urandom % 3 == 0), 1'($urandom % 8 == 0), "");
    end
    idle(); idle(); idle();

    // reset pulse must leave the array alone
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    chk("R1", {drive_o, dout_o}, {1'b0, {DW{1'b0}}});
    clear_pipe();
    for (int i = 0; i < 16; i++)
      issue(AW'(i), '0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R9");
    idle(); idle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule